// File: doc/BRIEF.md
# Timer and Event Counter with Prescaler

This block is an 8-bit up-counter that a processor core can preset, read and control with three commands. In timer mode it advances on the terminal count of a divide-by-32 prescaler that counts machine-cycle strobes. In event mode it advances on falling edges of an external input. The input is synchronized with two flip-flops and sampled once per machine-cycle strobe.

When the count rolls over from FFh to 00h, the block sets an overflow flag that software can test. It also sends a one-cycle interrupt request to the interrupt controller. A flag-test pulse clears the flag. Presetting the count to FFh in event mode turns the next falling edge on the input into an interrupt, which lets the input serve as a second external interrupt line.

All commands are single-cycle pulses. A command acts on the registered state from the next cycle on.

Top module: `tick_event_counter`

## Requirements
- R1: After reset the count reads 00h, the overflow flag and the interrupt request are low, and the counter is halted.
- R2: A load pulse writes loadData into the count, and the new value reads back one cycle later in every mode.
- R3: While halted (after reset or after a stop pulse), the count changes only by loads. A stop pulse in the same cycle as a start pulse leaves the counter halted.
- R4: In timer mode the count advances by one on every 32nd strobe. A start-timer pulse clears the prescaler, so the first advance comes on the 32nd strobe after the pulse cycle.
- R5: In event mode each high-to-low change of evtIn advances the count by one. The change is seen after two synchronizer flops, at the first strobe that samples the low level.
- R6: After an accepted falling edge, the next two strobes cannot accept another edge. An input that is low for one strobe period and high for one strobe period therefore advances the count on every second falling edge.
- R7: When the count wraps from FFh to 00h it keeps counting. In the cycle where 00h first reads back, ovfFlag is set and irqReq is high for exactly that one cycle.
- R8: A flag-test pulse clears ovfFlag from the next cycle. If a wrap happens in the same cycle, the flag stays set.
- R9: If a load and an advance fall in the same cycle, the load wins: the count takes loadData, and no flag or interrupt results even if the old count was FFh.
- R10: With the count preset to FFh in event mode, a single falling edge on evtIn produces one interrupt request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cycleStb | input | 1 | One-cycle machine-cycle strobe |
| evtIn | input | 1 | Asynchronous external event input |
| cmdStartTimer | input | 1 | Start timer mode and clear the prescaler |
| cmdStartCount | input | 1 | Start event mode |
| cmdStop | input | 1 | Halt counting (wins over a start in the same cycle) |
| cmdLoad | input | 1 | Load loadData into the count |
| loadData | input | 8 | Preset value |
| cmdTestFlag | input | 1 | Flag-test pulse; clears the overflow flag |
| countVal | output | 8 | Current count |
| ovfFlag | output | 1 | Overflow flag |
| irqReq | output | 1 | One-cycle interrupt request on wrap |

## Verification
Loads, commands and timer advances show on the outputs one cycle after the edge that takes them. An event edge needs two synchronizer cycles and then the next strobe before the count moves. A wrap's flag and interrupt come in the same cycle as the 00h count. The bench keeps a behavioural model that updates on the same edge as the design, and it compares all three outputs two nanoseconds after every rising edge. Directed checks wait a counted number of strobes before sampling. For the same-cycle cases (R8, R9), they place the pulse exactly on the 32nd strobe after a start.

// File: rtl/tec_pkg.sv
package tec_pkg;
  typedef enum logic [1:0] {
    MODE_IDLE  = 2'd0,
    MODE_TIMER = 2'd1,
    MODE_EVENT = 2'd2
  } runMode_t;

  typedef struct packed {
    logic load;
    logic inc;
    logic clrFlag;
  } ctlStrobe_t;
endpackage

// File: rtl/tec_control.sv
module tec_control
  import tec_pkg::*;
#(
  parameter int PRESCALE    = 32,
  parameter int SYNC_STAGES = 2,
  parameter int EVT_GAP     = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cycleStb,
  input  logic       evtIn,
  input  logic       cmdStartTimer,
  input  logic       cmdStartCount,
  input  logic       cmdStop,
  input  logic       cmdLoad,
  input  logic       cmdTestFlag,
  output ctlStrobe_t strobes
);
  localparam int PRE_W = (PRESCALE > 2) ? $clog2(PRESCALE) : 1;
  localparam int GAP_W = $clog2(EVT_GAP + 1) > 0 ? $clog2(EVT_GAP + 1) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);
  localparam logic [GAP_W-1:0] GAP_LOAD = GAP_W'(EVT_GAP);

  runMode_t         mode;
  logic [PRE_W-1:0] preCnt;
  logic [GAP_W-1:0] gapCnt;
  logic             evtLevel;
  logic             sampledLevel;
  logic             evtFall;
  logic             timerTick;
  logic             startTimerEff;

  // input synchronizer, depth picked by parameter
  generate
    if (SYNC_STAGES <= 1) begin : g_sync1
      logic syncReg;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncReg <= 1'b1;
        else       syncReg <= evtIn;
      end
      assign evtLevel = syncReg;
    end else begin : g_syncN
      logic [SYNC_STAGES-1:0] syncChain;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncChain <= '1;
        else       syncChain <= {syncChain[SYNC_STAGES-2:0], evtIn};
      end
      assign evtLevel = syncChain[SYNC_STAGES-1];
    end
  endgenerate

  // edge detection on strobe boundaries with a hold-off window
  assign evtFall = cycleStb && sampledLevel && !evtLevel && (gapCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sampledLevel <= 1'b1;
      gapCnt       <= '0;
    end else begin
      if (cycleStb) sampledLevel <= evtLevel;
      if (evtFall)                        gapCnt <= GAP_LOAD;
      else if (cycleStb && gapCnt != '0)  gapCnt <= gapCnt - 1'b1;
    end
  end

  // mode register: stop beats the starts, start-timer beats start-count
  assign startTimerEff = cmdStartTimer && !cmdStop;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              mode <= MODE_IDLE;
    else if (cmdStop)       mode <= MODE_IDLE;
    else if (cmdStartTimer) mode <= MODE_TIMER;
    else if (cmdStartCount) mode <= MODE_EVENT;
  end

  // prescaler
  assign timerTick = (mode == MODE_TIMER) && cycleStb && !startTimerEff
                     && (preCnt == PRE_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                preCnt <= '0;
    else if (startTimerEff)                   preCnt <= '0;
    else if (mode == MODE_TIMER && cycleStb)  preCnt <= (preCnt == PRE_LAST) ? '0 : preCnt + 1'b1;
  end

  always_comb begin
    strobes.load    = cmdLoad;
    strobes.inc     = timerTick || ((mode == MODE_EVENT) && evtFall);
    strobes.clrFlag = cmdTestFlag;
  end

  a_r4_start_clears_prescaler: assert property (@(posedge clk) disable iff (!rstN)
    startTimerEff |=> (preCnt == '0));
  a_r3_idle_no_inc: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_IDLE) |-> !strobes.inc);
  a_r6_no_back_to_back: assert property (@(posedge clk) disable iff (!rstN)
    evtFall |=> !evtFall);
endmodule

// File: rtl/tec_datapath.sv
module tec_datapath
  import tec_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobe_t       strobes,
  input  logic [CNT_W-1:0] loadData,
  output logic [CNT_W-1:0] countVal,
  output logic             ovfFlag,
  output logic             irqReq
);
  logic [CNT_W-1:0] cnt;
  logic             flag;
  logic             irq;
  logic             wrap;

  // a load masks the advance, so it cannot wrap
  assign wrap = strobes.inc && !strobes.load && (cnt == '1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt  <= '0;
      flag <= 1'b0;
      irq  <= 1'b0;
    end else begin
      if (strobes.load)     cnt <= loadData;
      else if (strobes.inc) cnt <= cnt + 1'b1;
      if (wrap)                 flag <= 1'b1;
      else if (strobes.clrFlag) flag <= 1'b0;
      irq <= wrap;
    end
  end

  assign countVal = cnt;
  assign ovfFlag  = flag;
  assign irqReq   = irq;

  a_r9_load_wins: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load |=> (cnt == $past(loadData)) && !irq);
  a_r8_flag_clear: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.clrFlag && !wrap) |=> !flag);
  a_r3_count_stable: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.inc && !strobes.load) |=> $stable(cnt));
endmodule

// File: rtl/tick_event_counter.sv
module tick_event_counter
  import tec_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int PRESCALE    = 32,
  parameter int SYNC_STAGES = 2,
  parameter int EVT_GAP     = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cycleStb,
  input  logic             evtIn,
  input  logic             cmdStartTimer,
  input  logic             cmdStartCount,
  input  logic             cmdStop,
  input  logic             cmdLoad,
  input  logic [CNT_W-1:0] loadData,
  input  logic             cmdTestFlag,
  output logic [CNT_W-1:0] countVal,
  output logic             ovfFlag,
  output logic             irqReq
);
  ctlStrobe_t strobes;

  tec_control #(
    .PRESCALE(PRESCALE), .SYNC_STAGES(SYNC_STAGES), .EVT_GAP(EVT_GAP)
  ) uControl (
    .clk(clk), .rstN(rstN), .cycleStb(cycleStb), .evtIn(evtIn),
    .cmdStartTimer(cmdStartTimer), .cmdStartCount(cmdStartCount),
    .cmdStop(cmdStop), .cmdLoad(cmdLoad), .cmdTestFlag(cmdTestFlag),
    .strobes(strobes)
  );

  tec_datapath #(.CNT_W(CNT_W)) uDatapath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .loadData(loadData),
    .countVal(countVal), .ovfFlag(ovfFlag), .irqReq(irqReq)
  );

  a_r7_wrap_reads_zero: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> (countVal == '0) && ovfFlag);
  a_r7_irq_single: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |=> !irqReq);
endmodule

// File: tb/sim_tick_event_counter.sv
module sim_tick_event_counter;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cycleStb = 1'b0;
  logic evtIn = 1'b1;
  logic cmdStartTimer = 1'b0, cmdStartCount = 1'b0, cmdStop = 1'b0;
  logic cmdLoad = 1'b0, cmdTestFlag = 1'b0;
  logic [7:0] loadData = 8'h00;
  logic [7:0] countVal;
  logic ovfFlag, irqReq;

  int nChecks = 0, nFails = 0, irqSeen = 0;
  string curReq = "R1";
  bit finished = 0;

  always #4 clk = ~clk;
  always @(negedge clk) cycleStb = ~cycleStb;

  tick_event_counter u0 (
    .clk(clk), .rstN(rstN), .cycleStb(cycleStb), .evtIn(evtIn),
    .cmdStartTimer(cmdStartTimer), .cmdStartCount(cmdStartCount),
    .cmdStop(cmdStop), .cmdLoad(cmdLoad), .loadData(loadData),
    .cmdTestFlag(cmdTestFlag), .countVal(countVal), .ovfFlag(ovfFlag),
    .irqReq(irqReq)
  );

  // behavioural reference model
  int mCnt = 0, mFlag = 0, mIrq = 0, mMode = 0, mPre = 0, mGap = 0;
  int mPrev = 1;
  int mSync[$] = '{1, 1};

  always @(posedge clk) begin
    if (!rstN) begin
      mCnt = 0; mFlag = 0; mIrq = 0; mMode = 0; mPre = 0; mGap = 0;
      mPrev = 1; mSync = '{1, 1};
    end else begin
      int lvl, nxtMode;
      bit fall, startT, tick, inc, wrap;
      lvl    = mSync[1];
      fall   = cycleStb && mPrev == 1 && lvl == 0 && mGap == 0;
      startT = cmdStartTimer && !cmdStop;
      tick   = mMode == 1 && cycleStb && !startT && mPre == 31;
      inc    = tick || (mMode == 2 && fall);
      wrap   = inc && !cmdLoad && mCnt == 255;
      if (cmdLoad) mCnt = loadData;
      else if (inc) mCnt = (mCnt + 1) % 256;
      if (wrap) mFlag = 1; else if (cmdTestFlag) mFlag = 0;
      mIrq = wrap ? 1 : 0;
      if (startT) mPre = 0;
      else if (mMode == 1 && cycleStb) mPre = (mPre + 1) % 32;
      nxtMode = mMode;
      if (cmdStop) nxtMode = 0;
      else if (cmdStartTimer) nxtMode = 1;
      else if (cmdStartCount) nxtMode = 2;
      mMode = nxtMode;
      if (fall) mGap = 2; else if (cycleStb && mGap > 0) mGap = mGap - 1;
      if (cycleStb) mPrev = lvl;
      mSync = '{int'(evtIn), mSync[0]};
    end
  end

  task automatic check(string req, string what, int got, int exp);
    nChecks++;
    if (got != exp) begin
      nFails++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  always @(posedge clk) begin
    #2;
    if (!finished) begin
      check(curReq, "countVal vs model", int'(countVal), mCnt);
      check(curReq, "ovfFlag vs model", int'(ovfFlag), mFlag);
      check(curReq, "irqReq vs model", int'(irqReq), mIrq);
      if (irqReq) irqSeen++;
    end
  end

  task automatic waitStrobes(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      while (!cycleStb) @(posedge clk);
    end
    #2;
  endtask

  // which: 0 startTimer, 1 startCount, 2 stop, 3 load, 4 test, 5 stop+startTimer
  task automatic pulse(int which, logic [7:0] d);
    @(negedge clk);
    loadData = d;
    case (which)
      0: cmdStartTimer = 1'b1;
      1: cmdStartCount = 1'b1;
      2: cmdStop = 1'b1;
      3: cmdLoad = 1'b1;
      4: cmdTestFlag = 1'b1;
      default: begin cmdStop = 1'b1; cmdStartTimer = 1'b1; end
    endcase
    @(negedge clk);
    cmdStartTimer = 0; cmdStartCount = 0; cmdStop = 0; cmdLoad = 0; cmdTestFlag = 0;
  endtask

  // assert a command on the strobe two clocks after the last counted strobe
  task automatic pulseOnNextStrobe(int which, logic [7:0] d);
    @(negedge clk);
    @(negedge clk);
    loadData = d;
    if (which == 3) cmdLoad = 1'b1; else cmdTestFlag = 1'b1;
    @(posedge clk);
    #2;
    @(negedge clk);
    cmdLoad = 0; cmdTestFlag = 0;
  endtask

  task automatic holdEvt(logic v, int clocks);
    @(negedge clk);
    evtIn = v;
    repeat (clocks - 1) @(negedge clk);
  endtask

  initial begin
    #200000;
    nChecks++; nFails++;
    $display("FAIL watchdog: got hung run expected completion");
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    int base, irqBefore;
    curReq = "R1";
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(posedge clk); #2;
    check("R1", "count after reset", int'(countVal), 0);
    check("R1", "flag after reset", int'(ovfFlag), 0);
    check("R1", "irq after reset", int'(irqReq), 0);

    curReq = "R3";
    holdEvt(1'b0, 8); holdEvt(1'b1, 8);
    waitStrobes(40);
    check("R3", "halted after reset", int'(countVal), 0);

    curReq = "R2";
    pulse(3, 8'h5A);
    check("R2", "loaded value", int'(countVal), 'h5A);

    curReq = "R4";
    pulse(0, 8'h00);
    waitStrobes(31);
    check("R4", "before 32nd strobe", int'(countVal), 'h5A);
    waitStrobes(1);
    check("R4", "at 32nd strobe", int'(countVal), 'h5B);
    waitStrobes(20);
    pulse(0, 8'h00);
    waitStrobes(31);
    check("R4", "restart clears prescaler", int'(countVal), 'h5B);
    waitStrobes(1);
    check("R4", "advance after restart", int'(countVal), 'h5C);

    curReq = "R3";
    pulse(2, 8'h00);
    waitStrobes(40);
    check("R3", "stop halts", int'(countVal), 'h5C);
    pulse(5, 8'h00);
    waitStrobes(40);
    check("R3", "stop beats start", int'(countVal), 'h5C);

    curReq = "R5";
    pulse(3, 8'h10);
    pulse(1, 8'h00);
    for (int k = 0; k < 3; k++) begin holdEvt(1'b0, 8); holdEvt(1'b1, 8); end
    waitStrobes(4);
    check("R5", "three falling edges", int'(countVal), 'h13);

    curReq = "R6";
    base = int'(countVal);
    for (int k = 0; k < 8; k++) begin holdEvt(1'b0, 2); holdEvt(1'b1, 2); end
    waitStrobes(6);
    check("R6", "rate limit on fast edges", int'(countVal), base + 4);

    curReq = "R10";
    pulse(3, 8'hFF);
    irqBefore = irqSeen;
    holdEvt(1'b0, 8); holdEvt(1'b1, 8);
    waitStrobes(4);
    check("R10", "one interrupt from preset FF", irqSeen - irqBefore, 1);
    check("R7", "wrapped count", int'(countVal), 0);
    check("R7", "flag set on wrap", int'(ovfFlag), 1);
    check("R7", "irq is a single pulse", int'(irqReq), 0);
    holdEvt(1'b0, 8); holdEvt(1'b1, 8);
    waitStrobes(4);
    check("R7", "keeps counting after wrap", int'(countVal), 1);

    curReq = "R8";
    pulse(4, 8'h00);
    check("R8", "flag cleared by test", int'(ovfFlag), 0);
    pulse(3, 8'hFF);
    pulse(0, 8'h00);
    waitStrobes(31);
    pulseOnNextStrobe(4, 8'h00);
    check("R8", "wrap beats test", int'(ovfFlag), 1);
    check("R8", "wrapped under test", int'(countVal), 0);

    curReq = "R9";
    pulse(4, 8'h00);
    pulse(3, 8'hFF);
    pulse(0, 8'h00);
    irqBefore = irqSeen;
    waitStrobes(31);
    pulseOnNextStrobe(3, 8'h77);
    check("R9", "load wins over advance", int'(countVal), 'h77);
    check("R9", "no flag from masked wrap", int'(ovfFlag), 0);
    check("R9", "no irq from masked wrap", irqSeen - irqBefore, 0);

    waitStrobes(4);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule